// File: doc/BRIEF.md
# Prescaled Match Timer Counter

This block is a free-running up-counter with a programmable prescale stage and a bank of match channels. In clock mode a prescale counter runs on every clock and lets the main count advance once every `PR+1` clocks. In edge mode the prescaler is idle and the main count advances once for each qualifying transition of an external input. The external input passes through a two-flop synchroniser first. The rising, falling or both-edge choice comes from a control field.

Each match channel compares its own match value against the count and carries three action bits. One bit records an event in a sticky flag. One bit restarts the count from zero after the count has spent a full tick at the match value. One bit halts the timer by clearing its run bit. Software programs the block through a simple write port with a combinational read port. It clears flags by writing ones. A single interrupt line is the OR of all flags.

Register addresses (`reg_addr`): 0 control, 1 prescale limit, 2 action bits, 3 flags, 4 main count (read only), 5 prescale count (read only), 8+c match value of channel c. Control bits: bit 0 run, bit 1 hold-clear, bits 3:2 count source.

Top module: `pmt_timer`

## Requirements
- R1: In clock mode (control bits 3:2 = 00) with run set, the main count (address 4) advances once every PR+1 clocks, where PR is the value at address 1, and the first advance happens PR+1 clock edges after the edge that sets run.
- R2: When no reset action applies, the main count passes its match values and steps from all ones to zero on the next tick.
- R3: With a channel's reset action set (action bit 3c+1), the main count runs 0,1,…,MR and back to 0, so one period lasts (PR+1)*(MR+1) clocks.
- R4: A match event on channel c happens on a tick whose new count equals that channel's match value. If action bit 3c+0 is set, flag bit c (address 3) becomes 1.
- R5: On a match event of a channel whose action bit 3c+2 is set, the run bit (control bit 0) clears. The main count then stays at the match value and the prescale count holds until software sets run again.
- R6: Flags stay set until a 1 is written to their bit at address 3. Writing 0 leaves them unchanged. `irq` is high exactly when at least one flag is set.
- R7: While control bit 1 (hold-clear) is set, the main count and the prescale count both read 0, even with run set.
- R8: With control bits 3:2 = 01, 10 or 11, the main count advances once per rising, falling or any transition of `ext_in`, respectively. The prescale count stays 0 in this mode.
- R9: After reset every register reads 0, and `irq` and `match_flags` are low.
- R10: Channels act independently. A reset action on one channel and a flag action on another both take effect within the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register address for write and read |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Combinational read data for `reg_addr` |
| ext_in | input | 1 | Asynchronous external count input |
| match_flags | output | N_CH | Sticky per-channel match flags |
| irq | output | 1 | OR of all match flags |

## Verification
The bench builds the block with an 8-bit count (`CNT_W=8`) and the default four channels. The short count lets a wrap from 255 to 0 happen within a few hundred clocks. The same path at 32 bits would need billions of clocks. Four channels allow a stop on one channel, a reset on another and a flag on a third to be set up side by side. Prescale limits of 0 to 5 and match values from 0 to 100 exercise both the single-clock tick and longer prescaled ticks.

// File: rtl/pmt_pkg.sv
// Shared constants for the prescaled match timer.
// Assumes an address bus of at least 4 bits and at most 8 match channels.
package pmt_pkg;

    // Count source selection, control bits 3:2
    typedef enum logic [1:0] {
        SRC_CLOCK = 2'b00,
        SRC_RISE  = 2'b01,
        SRC_FALL  = 2'b10,
        SRC_BOTH  = 2'b11
    } src_sel_e;

    // Register addresses
    localparam int A_CTRL   = 0;
    localparam int A_PRESC  = 1;
    localparam int A_ACT    = 2;
    localparam int A_FLAG   = 3;
    localparam int A_COUNT  = 4;
    localparam int A_PCNT   = 5;
    localparam int A_MATCH0 = 8;

    // Control bit positions
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_HOLD = 1;
    localparam int CTRL_SRC  = 2;

    // Per-channel action bit offsets
    localparam int ACT_IRQ  = 0;
    localparam int ACT_CLR  = 1;
    localparam int ACT_STOP = 2;
    localparam int ACT_BITS = 3;

endpackage

// File: rtl/pmt_edge_sync.sv
// Brings the asynchronous external input into the clock domain with two
// flops, then produces a one-clock pulse for the selected transition kind.
// Assumes ext_in stays stable for at least two clocks between transitions.
module pmt_edge_sync
    import pmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_in,
    input  logic [1:0] src_sel,
    output logic       edge_pulse
);

    logic meta_q, sync_q, prev_q;
    logic rise, fall;

    // Two-stage synchroniser plus a delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= ext_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;

    // Pick which transitions count
    always_comb begin
        case (src_sel)
            SRC_RISE: edge_pulse = rise;
            SRC_FALL: edge_pulse = fall;
            SRC_BOTH: edge_pulse = rise | fall;
            default:  edge_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmt_prescaler.sv
// Prescale stage: in clock mode counts clocks up to the limit and emits a
// tick on the clock where the count has reached it; in edge mode passes the
// external pulse through and keeps its own count at zero.
// Assumes run and hold come straight from the control register.
module pmt_prescaler #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    input  logic             use_clock,
    input  logic [CNT_W-1:0] limit,
    input  logic             ext_pulse,
    output logic             tick,
    output logic [CNT_W-1:0] pcount
);

    logic at_limit;

    // At or beyond the limit (a limit lowered mid-count still wraps)
    assign at_limit = (pcount >= limit);

    // Tick generation for both count sources
    always_comb begin
        if (!run || hold)
            tick = 1'b0;
        else if (use_clock)
            tick = at_limit;
        else
            tick = ext_pulse;
    end

    // Prescale counter state
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcount <= '0;
        else if (hold || !use_clock)
            pcount <= '0;
        else if (run)
            pcount <= at_limit ? '0 : pcount + 1'b1;
    end

endmodule

// File: rtl/pmt_count_core.sv
// Main counter with the match comparators of all channels. Works out the
// next count (restart or increment with natural wrap), raises per-channel
// events when the new count equals a match value, and collects the flag
// and stop requests from the action bits.
// Assumes match values and action bits come from registers.
module pmt_count_core
    import pmt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int N_CH  = 4,
    localparam int ACT_W = ACT_BITS * N_CH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               hold,
    input  logic [N_CH*CNT_W-1:0] match_flat,
    input  logic [ACT_W-1:0]   act_bits,
    output logic [CNT_W-1:0]   count,
    output logic [N_CH-1:0]    flag_set,
    output logic               stop_req
);

    logic [N_CH-1:0]  restart_req;
    logic [N_CH-1:0]  evt;
    logic [N_CH-1:0]  stop_hit;
    logic [CNT_W-1:0] cnt_next;

    // Restart wins over increment when any channel asks for it
    assign cnt_next = (|restart_req) ? '0 : count + 1'b1;

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        logic [CNT_W-1:0] mval;
        assign mval           = match_flat[c*CNT_W +: CNT_W];
        assign restart_req[c] = (count == mval) & act_bits[c*ACT_BITS + ACT_CLR];
        assign evt[c]         = tick & (cnt_next == mval);
        assign flag_set[c]    = evt[c] & act_bits[c*ACT_BITS + ACT_IRQ];
        assign stop_hit[c]    = evt[c] & act_bits[c*ACT_BITS + ACT_STOP];
    end

    assign stop_req = |stop_hit;

    // Main count register
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (hold)
            count <= '0;
        else if (tick)
            count <= cnt_next;
    end

endmodule

// File: rtl/pmt_timer.sv
// Top of the prescaled match timer: register file, read mux and the wiring
// of synchroniser, prescaler and count core.
// Assumes CNT_W <= BUS_W, 3*N_CH <= BUS_W and N_CH <= 8.
module pmt_timer
    import pmt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int N_CH   = 4,
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic              ext_in,
    output logic [N_CH-1:0]   match_flags,
    output logic              irq
);

    localparam int ACT_W = ACT_BITS * N_CH;

    logic             run_q, hold_q;
    logic [1:0]       src_q;
    logic [CNT_W-1:0] presc_q;
    logic [ACT_W-1:0] act_q;
    logic [N_CH-1:0]  flags_q;
    logic [CNT_W-1:0] match_q [N_CH];
    logic [N_CH*CNT_W-1:0] match_flat;

    logic             use_clock, ext_pulse, tick, stop_req;
    logic [CNT_W-1:0] pcount, count;
    logic [N_CH-1:0]  flag_set;

    logic wr_ctrl, wr_presc, wr_act, wr_flag;

    assign wr_ctrl  = reg_we && (reg_addr == ADDR_W'(A_CTRL));
    assign wr_presc = reg_we && (reg_addr == ADDR_W'(A_PRESC));
    assign wr_act   = reg_we && (reg_addr == ADDR_W'(A_ACT));
    assign wr_flag  = reg_we && (reg_addr == ADDR_W'(A_FLAG));

    assign use_clock = (src_q == SRC_CLOCK);

    // Control register; a stop request overrides a software write of run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            hold_q <= 1'b0;
            src_q  <= 2'b00;
        end else begin
            if (wr_ctrl) begin
                run_q  <= reg_wdata[CTRL_RUN];
                hold_q <= reg_wdata[CTRL_HOLD];
                src_q  <= reg_wdata[CTRL_SRC +: 2];
            end
            if (stop_req)
                run_q <= 1'b0;
        end
    end

    // Prescale limit and action bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            act_q   <= '0;
        end else begin
            if (wr_presc) presc_q <= reg_wdata[CNT_W-1:0];
            if (wr_act)   act_q   <= reg_wdata[ACT_W-1:0];
        end
    end

    // Match value registers, one per channel
    for (genvar c = 0; c < N_CH; c++) begin : g_match
        always_ff @(posedge clk) begin
            if (!rst_n)
                match_q[c] <= '0;
            else if (reg_we && (reg_addr == ADDR_W'(A_MATCH0 + c)))
                match_q[c] <= reg_wdata[CNT_W-1:0];
        end
        assign match_flat[c*CNT_W +: CNT_W] = match_q[c];
    end

    // Sticky flags: new events win over a clear in the same clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= (flags_q & ~(wr_flag ? reg_wdata[N_CH-1:0] : '0)) | flag_set;
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_CTRL):  reg_rdata = BUS_W'({src_q, hold_q, run_q});
            ADDR_W'(A_PRESC): reg_rdata = BUS_W'(presc_q);
            ADDR_W'(A_ACT):   reg_rdata = BUS_W'(act_q);
            ADDR_W'(A_FLAG):  reg_rdata = BUS_W'(flags_q);
            ADDR_W'(A_COUNT): reg_rdata = BUS_W'(count);
            ADDR_W'(A_PCNT):  reg_rdata = BUS_W'(pcount);
            default: begin
                for (int c = 0; c < N_CH; c++)
                    if (reg_addr == ADDR_W'(A_MATCH0 + c))
                        reg_rdata = BUS_W'(match_q[c]);
            end
        endcase
    end

    pmt_edge_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_in     (ext_in),
        .src_sel    (src_q),
        .edge_pulse (ext_pulse)
    );

    pmt_prescaler #(.CNT_W(CNT_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .hold      (hold_q),
        .use_clock (use_clock),
        .limit     (presc_q),
        .ext_pulse (ext_pulse),
        .tick      (tick),
        .pcount    (pcount)
    );

    pmt_count_core #(.CNT_W(CNT_W), .N_CH(N_CH)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .hold       (hold_q),
        .match_flat (match_flat),
        .act_bits   (act_q),
        .count      (count),
        .flag_set   (flag_set),
        .stop_req   (stop_req)
    );

    assign match_flags = flags_q;
    assign irq         = |flags_q;

endmodule

// File: rtl/pmt_timer_chk.sv
// Property checker for pmt_timer, attached through bind.
// Assumes synchronous active-low reset on rst_n.
module pmt_timer_chk #(
    parameter int CNT_W  = 32,
    parameter int N_CH   = 4,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              run,
    input logic              hold,
    input logic              stop_req,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  pcount,
    input logic [N_CH-1:0]   flags
);

    // R7
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (count == '0) && (pcount == '0));

    // R5
    stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !run);

    // R5
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !hold) |=> $stable(count) && $stable(pcount));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == ADDR_W'(3)) |=> ((flags & $past(flags)) == $past(flags)));

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> (count == $past(count)) || (count == $past(count) + 1'b1) || (count == '0));

endmodule

bind pmt_timer pmt_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .run      (run_q),
    .hold     (hold_q),
    .stop_req (stop_req),
    .count    (count),
    .pcount   (pcount),
    .flags    (flags_q)
);

// File: tb/tb_pmt_timer.sv
module tb_pmt_timer;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 8;
    localparam int N_CH   = 4;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [BUS_W-1:0]  reg_wdata = '0;
    logic [BUS_W-1:0]  reg_rdata;
    logic              ext_in = 1'b0;
    logic [N_CH-1:0]   match_flags;
    logic              irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmt_timer #(.CNT_W(CNT_W), .N_CH(N_CH), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_in(ext_in),
        .match_flags(match_flags), .irq(irq)
    );

    // pr, mr0, action bits, clocks after enable, expected count, expected flag0
    typedef struct packed {
        int pr; int mr; int act; int n; int exp_cnt; int exp_flag;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{0, 9,   3, 7,   7, 0},   // R3 before reaching MR
        '{0, 4,   3, 12,  2, 1},   // R3 two periods of 5
        '{3, 5,   3, 30,  1, 1},   // R1 R3 7 ticks mod 6
        '{2, 100, 3, 10,  3, 0},   // R1 3 ticks
        '{1, 3,   1, 20, 10, 1},   // R2 R4 counts past MR
        '{4, 0,   3, 23,  0, 1},   // R3 MR=0 period PR+1
        '{0, 0,   0, 260, 4, 0}    // R2 wrap 255->0
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = ADDR_W'(addr); reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        reg_addr = ADDR_W'(addr);
        #1;
        data = reg_rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reinit();
        wr(0, 32'h2);          // hold-clear, run off, clock source
        wr(3, 32'hF);          // clear all flags
        wr(2, 32'h0);
        for (int c = 0; c < N_CH; c++) wr(8 + c, 32'hFF);
    endtask

    task automatic pulses(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); ext_in = 1'b1;
            wait_clk(3);
            ext_in = 1'b0;
            wait_clk(3);
        end
        wait_clk(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        wait_clk(3);
        @(negedge clk); rst_n = 1'b1;

        // R9 reset state
        rd(0, v); check("R9 ctrl", v, 0);
        rd(4, v); check("R9 count", v, 0);
        rd(3, v); check("R9 flags", v, 0);
        check("R9 irq", {31'd0, irq}, 0);

        // Table walk: R1 R2 R3 R4
        foreach (VECS[i]) begin
            reinit();
            wr(1, VECS[i].pr);
            wr(8, VECS[i].mr);
            wr(2, VECS[i].act);
            wr(0, 32'h1);
            wait_clk(VECS[i].n);
            rd(4, v); check("R1/R2/R3 count", v, VECS[i].exp_cnt);
            rd(3, v); check("R4 flag0", v & 32'h1, VECS[i].exp_flag);
        end

        // R1 prescale count readback: pr=3, 6 clocks -> pcount 2
        reinit();
        wr(1, 3); wr(0, 32'h1);
        wait_clk(6);
        rd(5, v); check("R1 pcount", v, 2);

        // R5 stop on channel 1 at 3, with flag
        reinit();
        wr(1, 0); wr(9, 3); wr(2, 32'h28);
        wr(0, 32'h1);
        wait_clk(10);
        rd(4, v); check("R5 count held", v, 3);
        rd(0, v); check("R5 run cleared", v, 0);
        rd(3, v); check("R4 flag1", v, 2);

        // R6 write 0 keeps, write 1 clears
        wr(3, 32'h0);
        rd(3, v); check("R6 write0 keeps", v, 2);
        check("R6 irq high", {31'd0, irq}, 1);
        wr(3, 32'h2);
        rd(3, v); check("R6 cleared", v, 0);
        check("R6 irq low", {31'd0, irq}, 0);

        // R5 restart resumes from held value
        wr(2, 32'h0); wr(0, 32'h1);
        wait_clk(2);
        rd(4, v); check("R5 resume", v, 5);

        // R10 ch2 restart at 2, ch0 flag at 1, 7 ticks
        reinit();
        wr(1, 0); wr(8, 1); wr(10, 2); wr(2, 32'h81);
        wr(0, 32'h1);
        wait_clk(7);
        rd(4, v); check("R10 count", v, 1);
        rd(3, v); check("R10 flags", v, 1);

        // R7 hold-clear with run set
        reinit();
        wr(1, 0); wr(0, 32'h3);
        wait_clk(10);
        rd(4, v); check("R7 count", v, 0);
        rd(5, v); check("R7 pcount", v, 0);
        wr(0, 32'h1);
        wait_clk(5);
        rd(4, v); check("R7 after release", v, 5);

        // R8 edge modes: 3 pulses each
        reinit();
        wr(1, 5); wr(0, 32'h5);
        pulses(3);
        rd(4, v); check("R8 rising", v, 3);
        rd(5, v); check("R8 pcount zero", v, 0);
        reinit();
        wr(0, 32'h9);
        pulses(3);
        rd(4, v); check("R8 falling", v, 3);
        reinit();
        wr(0, 32'hD);
        pulses(3);
        rd(4, v); check("R8 both", v, 6);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule